// File: doc/BRIEF.md
# Oscillator Configuration Loader

This block is the programming front end of a numerically controlled oscillator. A host writes 16-bit words over a simple strobed bus into seven holding registers. The holding registers are the low and high halves of the center frequency, the low and high halves of the frequency offset, the low and high halves of the timer interval, and a phase offset word. The host selects each one with a 3-bit address. Writing a holding register does not change anything the oscillator sees.

The oscillator clock domain picks up new settings through five active-low load inputs. There are four register loads (center, offset, timer interval, phase) and one timer arm. Each load input is first captured in a flop. The captured value then acts as the clock enable of its working register, so a working register copies its holding value on the second rising edge after the load input is first seen low. For as long as the load input stays low, the working register copies its holding value again on every edge. This lets a host assemble a full 32-bit word from two halves and move it to the oscillator in one step.

Top module: `nco_cfg_loader`

## Requirements
- R1: A synchronous active-low reset clears the working registers, the holding registers and the timer arm output to zero, and puts every captured load enable into its inactive (high) state.
- R2: With `cs_n` and `wr_n` both low at a rising edge, address 0 writes the low half and address 1 writes the high half of the center frequency holding pair. The working center frequency is formed as {high half, low half}.
- R3: Addresses 2 and 3 write the low and high halves of the offset pair, and addresses 4 and 5 write the low and high halves of the timer interval pair. Address 6 writes the 16-bit phase word. Each pair is loaded as {high, low}.
- R4: A write to address 7 changes no holding register.
- R5: While `cs_n` is high, no holding register is written, whatever the address and `wr_n`.
- R6: While `wr_n` is high, no holding register is written, whatever the address.
- R7: A working register takes its new value on the second rising edge after its load input is sampled low. It still holds its old value after the first edge, and it never changes without such a load.
- R8: While a load input stays low, its working register copies the holding register on every edge. A holding write at edge k is therefore visible at edge k+1.
- R9: Each load input affects only its own working register.
- R10: `tmr_arm` goes high on the second edge after `ld_arm_n` is sampled low. It stays high one cycle for each cycle `ld_arm_n` was low, and then goes low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Holding register select |
| wr_data | input | 16 | Write data |
| ld_ctr_n | input | 1 | Load center frequency, active low |
| ld_off_n | input | 1 | Load frequency offset, active low |
| ld_tmr_n | input | 1 | Load timer interval, active low |
| ld_arm_n | input | 1 | Timer arm request, active low |
| ld_phs_n | input | 1 | Load phase offset, active low |
| ctr_freq | output | 32 | Working center frequency |
| off_freq | output | 32 | Working frequency offset |
| tmr_ival | output | 32 | Working timer interval |
| phs_ofs | output | 16 | Working phase offset |
| tmr_arm | output | 1 | Staged timer arm |

## Verification
A holding register that is corrupted or decoded to the wrong slot cannot be seen until a later load moves it to a working register. The bench therefore follows every write sequence with a load and compares all four working outputs two edges later. A captured enable that is stuck or skipped shows up one edge early or one edge late. Each load is therefore checked on both the first and the second edge after it, and the untouched registers are checked at the same time. In the held-enable sequence, a holding write reaches the outputs in one edge, which exposes a broken reload-every-cycle path immediately.

// File: rtl/nco_cfg_pkg.sv
// Package: shared constants and slot encoding for the oscillator
// configuration loader. Assumes a 3-bit address space of which seven
// codes name holding slots and the last code is unused.
package nco_cfg_pkg;

    localparam int unsigned ADDR_W   = 3;
    localparam int unsigned HOLD_CNT = 7;
    localparam int unsigned LD_CNT   = 5;

    // Slot codes; the numeric values are the bus addresses.
    typedef enum logic [ADDR_W-1:0] {
        SLOT_CTR_LO = 3'd0,
        SLOT_CTR_HI = 3'd1,
        SLOT_OFF_LO = 3'd2,
        SLOT_OFF_HI = 3'd3,
        SLOT_TMR_LO = 3'd4,
        SLOT_TMR_HI = 3'd5,
        SLOT_PHS    = 3'd6,
        SLOT_NONE   = 3'd7
    } slot_e;

    // Bit positions of the load enables inside the packed load vector.
    localparam int unsigned LD_CTR = 0;
    localparam int unsigned LD_OFF = 1;
    localparam int unsigned LD_TMR = 2;
    localparam int unsigned LD_ARM = 3;
    localparam int unsigned LD_PHS = 4;

endpackage

// File: rtl/cfg_addr_decode.sv
// Module: address decoder for the holding slots.
// Produces at most one write select per cycle. Assumes cs_n and wr_n are
// synchronous to clk; addresses at or above SLOTS select nothing.
module cfg_addr_decode
    import nco_cfg_pkg::*;
#(
    parameter int unsigned AW    = ADDR_W,
    parameter int unsigned SLOTS = HOLD_CNT
) (
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic [AW-1:0]    addr,
    output logic [SLOTS-1:0] wr_sel
);

    logic strobe;

    // Qualify the write: both active-low controls must be asserted.
    assign strobe = !cs_n && !wr_n;

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_sel
            // One comparator per slot; the address code equals the slot index.
            assign wr_sel[s] = strobe && (addr == AW'(s));
        end
    endgenerate

endmodule

// File: rtl/cfg_hold_bank.sv
// Module: bank of host-written holding registers.
// Each slot captures the data bus on a rising edge when its select is high
// and otherwise keeps its value. Assumes at most one select is high.
module cfg_hold_bank #(
    parameter int unsigned DW    = 16,
    parameter int unsigned SLOTS = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SLOTS-1:0]           wr_sel,
    input  logic [DW-1:0]              wr_data,
    output logic [SLOTS-1:0][DW-1:0]   hold
);

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            logic [DW-1:0] slot_q;

            // Capture the bus into this slot when selected.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot_q <= '0;
                else if (wr_sel[s])
                    slot_q <= wr_data;
            end

            assign hold[s] = slot_q;
        end
    endgenerate

endmodule

// File: rtl/cfg_stage_en.sv
// Module: first pipeline stage of the active-low load enables.
// Captures every enable once per clock; reset parks them inactive (high)
// so that no working register loads in the first cycle after reset.
module cfg_stage_en #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ld_n,
    output logic [N-1:0] ld_stg_n
);

    // Register the raw enables; inactive value on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ld_stg_n <= '1;
        else
            ld_stg_n <= ld_n;
    end

endmodule

// File: rtl/cfg_ctrl_reg.sv
// Module: one working register fed from holding registers.
// Loads src on every edge while the staged enable is low, else holds.
// Assumes src is stable for the edge after the enable was staged.
module cfg_ctrl_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_stg_n,
    input  logic [W-1:0] src,
    output logic [W-1:0] q
);

    // Copy the holding value while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (!ld_stg_n)
            q <= src;
    end

endmodule

// File: rtl/nco_cfg_loader.sv
// Module: oscillator configuration loader (top).
// Host writes land in holding slots; active-low load inputs are staged one
// edge and then gate the working registers on the next edge. Assumes all
// inputs are synchronous to clk; no clock-domain crossing is done here.
module nco_cfg_loader
    import nco_cfg_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  wr_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  ld_ctr_n,
    input  logic                  ld_off_n,
    input  logic                  ld_tmr_n,
    input  logic                  ld_arm_n,
    input  logic                  ld_phs_n,
    output logic [2*DATA_W-1:0]   ctr_freq,
    output logic [2*DATA_W-1:0]   off_freq,
    output logic [2*DATA_W-1:0]   tmr_ival,
    output logic [DATA_W-1:0]     phs_ofs,
    output logic                  tmr_arm
);

    localparam int unsigned WIDE_W = 2 * DATA_W;

    logic [HOLD_CNT-1:0]             wr_sel;
    logic [HOLD_CNT-1:0][DATA_W-1:0] hold;
    logic [LD_CNT-1:0]               ld_vec;
    logic [LD_CNT-1:0]               ld_stg_n;

    // Pack the load inputs by their package bit positions.
    assign ld_vec = {ld_phs_n, ld_arm_n, ld_tmr_n, ld_off_n, ld_ctr_n};

    cfg_addr_decode #(.AW(ADDR_W), .SLOTS(HOLD_CNT)) dec_i (
        .cs_n   (cs_n),
        .wr_n   (wr_n),
        .addr   (addr),
        .wr_sel (wr_sel)
    );

    cfg_hold_bank #(.DW(DATA_W), .SLOTS(HOLD_CNT)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .hold    (hold)
    );

    cfg_stage_en #(.N(LD_CNT)) stage_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_n     (ld_vec),
        .ld_stg_n (ld_stg_n)
    );

    cfg_ctrl_reg #(.W(WIDE_W)) ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_stg_n (ld_stg_n[LD_CTR]),
        .src      ({hold[SLOT_CTR_HI], hold[SLOT_CTR_LO]}),
        .q        (ctr_freq)
    );

    cfg_ctrl_reg #(.W(WIDE_W)) off_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_stg_n (ld_stg_n[LD_OFF]),
        .src      ({hold[SLOT_OFF_HI], hold[SLOT_OFF_LO]}),
        .q        (off_freq)
    );

    cfg_ctrl_reg #(.W(WIDE_W)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_stg_n (ld_stg_n[LD_TMR]),
        .src      ({hold[SLOT_TMR_HI], hold[SLOT_TMR_LO]}),
        .q        (tmr_ival)
    );

    cfg_ctrl_reg #(.W(DATA_W)) phs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_stg_n (ld_stg_n[LD_PHS]),
        .src      (hold[SLOT_PHS]),
        .q        (phs_ofs)
    );

    // Second stage of the arm request: follows the staged enable, inverted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tmr_arm <= 1'b0;
        else
            tmr_arm <= !ld_stg_n[LD_ARM];
    end

endmodule

// Checker: timing and decode properties of the configuration loader.
// Attached to every instance of the top through the bind below.
module cfg_loader_chk
    import nco_cfg_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs_n,
    input logic                  wr_n,
    input logic [ADDR_W-1:0]     addr,
    input logic [HOLD_CNT-1:0]   wr_sel,
    input logic                  ld_ctr_n,
    input logic                  ld_off_n,
    input logic                  ld_tmr_n,
    input logic                  ld_arm_n,
    input logic                  ld_phs_n,
    input logic [2*DATA_W-1:0]   ctr_freq,
    input logic [2*DATA_W-1:0]   off_freq,
    input logic [2*DATA_W-1:0]   tmr_ival,
    input logic [DATA_W-1:0]     phs_ofs,
    input logic                  tmr_arm
);

    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

    // R4
    rsvd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == SLOT_NONE) |-> (wr_sel == '0));

    // R5
    cs_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (wr_sel == '0));

    // R6
    wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_n |-> (wr_sel == '0));

    // R7
    ctr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (ctr_freq != $past(ctr_freq))) |-> !$past(ld_ctr_n, 2));

    // R7
    off_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (off_freq != $past(off_freq))) |-> !$past(ld_off_n, 2));

    // R7
    tmr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (tmr_ival != $past(tmr_ival))) |-> !$past(ld_tmr_n, 2));

    // R7
    phs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (phs_ofs != $past(phs_ofs))) |-> !$past(ld_phs_n, 2));

    // R10
    arm_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (tmr_arm == !$past(ld_arm_n, 2)));

endmodule

bind nco_cfg_loader cfg_loader_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .wr_n     (wr_n),
    .addr     (addr),
    .wr_sel   (wr_sel),
    .ld_ctr_n (ld_ctr_n),
    .ld_off_n (ld_off_n),
    .ld_tmr_n (ld_tmr_n),
    .ld_arm_n (ld_arm_n),
    .ld_phs_n (ld_phs_n),
    .ctr_freq (ctr_freq),
    .off_freq (off_freq),
    .tmr_ival (tmr_ival),
    .phs_ofs  (phs_ofs),
    .tmr_arm  (tmr_arm)
);

// File: tb/nco_cfg_loader_tb_top.sv
// Scoreboard bench: driver tasks push expected output values with the cycle
// they are due; a negedge monitor pops and compares them.
module nco_cfg_loader_tb_top;

    logic        clk = 1'b0;
    logic        rst_n, cs_n, wr_n;
    logic [2:0]  addr;
    logic [15:0] wr_data;
    logic        ld_ctr_n, ld_off_n, ld_tmr_n, ld_arm_n, ld_phs_n;
    logic [31:0] ctr_freq, off_freq, tmr_ival;
    logic [15:0] phs_ofs;
    logic        tmr_arm;

    always #10 clk = ~clk;

    nco_cfg_loader #(.DATA_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
        .wr_data(wr_data), .ld_ctr_n(ld_ctr_n), .ld_off_n(ld_off_n),
        .ld_tmr_n(ld_tmr_n), .ld_arm_n(ld_arm_n), .ld_phs_n(ld_phs_n),
        .ctr_freq(ctr_freq), .off_freq(off_freq), .tmr_ival(tmr_ival),
        .phs_ofs(phs_ofs), .tmr_arm(tmr_arm)
    );

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Reference model of the holding and working registers.
    logic [15:0] m_hold [7];
    logic [31:0] m_ctr = '0, m_off = '0, m_tmr = '0;
    logic [15:0] m_phs = '0;

    typedef struct {
        int          kind;
        logic [31:0] val;
        int          due;
        string       tag;
    } exp_t;
    exp_t sb[$];

    function automatic logic [31:0] observe(int k);
        case (k)
            0:       return ctr_freq;
            1:       return off_freq;
            2:       return tmr_ival;
            3:       return {16'h0, phs_ofs};
            default: return {31'h0, tmr_arm};
        endcase
    endfunction

    task automatic check_now(string tag, int k, logic [31:0] v);
        logic [31:0] act;
        act = observe(k);
        n_cmp++;
        if (act !== v) begin
            n_bad++;
            $display("FAIL %s output#%0d cycle %0d actual=%h expected=%h", tag, k, cyc, act, v);
        end
    endtask

    task automatic expect_at(int k, logic [31:0] v, int due, string tag);
        exp_t e;
        e.kind = k; e.val = v; e.due = due; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare every item due in this cycle.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                check_now(sb[i].tag, sb[i].kind, sb[i].val);
                sb.delete(i);
            end
        end
    end

    // One bus cycle; called at a negedge, returns at the next negedge.
    task automatic bus_write(logic [2:0] a, logic [15:0] d, logic c, logic w);
        cs_n = c; wr_n = w; addr = a; wr_data = d;
        if (!c && !w && a != 3'd7) m_hold[a] = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    // One-cycle load pulse. mask bits: 0 center, 1 offset, 2 timer, 3 phase.
    task automatic download(bit [3:0] mask, string tag);
        int c;
        c = cyc;
        // R7: one edge after the sample nothing has changed yet.
        expect_at(0, m_ctr, c + 1, "R7");
        expect_at(1, m_off, c + 1, "R7");
        expect_at(2, m_tmr, c + 1, "R7");
        expect_at(3, {16'h0, m_phs}, c + 1, "R7");
        if (mask[0]) m_ctr = {m_hold[1], m_hold[0]};
        if (mask[1]) m_off = {m_hold[3], m_hold[2]};
        if (mask[2]) m_tmr = {m_hold[5], m_hold[4]};
        if (mask[3]) m_phs = m_hold[6];
        // R9: registers not loaded keep their value.
        expect_at(0, m_ctr, c + 2, mask[0] ? tag : "R9");
        expect_at(1, m_off, c + 2, mask[1] ? tag : "R9");
        expect_at(2, m_tmr, c + 2, mask[2] ? tag : "R9");
        expect_at(3, {16'h0, m_phs}, c + 2, mask[3] ? tag : "R9");
        ld_ctr_n = !mask[0]; ld_off_n = !mask[1];
        ld_tmr_n = !mask[2]; ld_phs_n = !mask[3];
        @(negedge clk);
        ld_ctr_n = 1'b1; ld_off_n = 1'b1; ld_tmr_n = 1'b1; ld_phs_n = 1'b1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog (all R) actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int c;
        for (int i = 0; i < 7; i++) m_hold[i] = '0;
        rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; addr = '0; wr_data = '0;
        ld_ctr_n = 1'b0; ld_off_n = 1'b0; ld_tmr_n = 1'b0; ld_arm_n = 1'b0; ld_phs_n = 1'b0;
        repeat (3) @(negedge clk);
        ld_ctr_n = 1'b1; ld_off_n = 1'b1; ld_tmr_n = 1'b1; ld_arm_n = 1'b1; ld_phs_n = 1'b1;
        // R1: state while in reset.
        for (int k = 0; k < 5; k++) check_now("R1", k, '0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 5; k++) check_now("R1", k, '0);
        // R1: holding registers cleared, seen through a full load.
        download(4'b1111, "R1");

        // R2: center pair.
        bus_write(3'd0, 16'h1234, 1'b0, 1'b0);
        bus_write(3'd1, 16'hABCD, 1'b0, 1'b0);
        download(4'b0001, "R2");

        // R3: offset, timer, phase.
        bus_write(3'd2, 16'h0F0E, 1'b0, 1'b0);
        bus_write(3'd3, 16'h7788, 1'b0, 1'b0);
        bus_write(3'd4, 16'hC001, 1'b0, 1'b0);
        bus_write(3'd5, 16'h0042, 1'b0, 1'b0);
        bus_write(3'd6, 16'h9A5B, 1'b0, 1'b0);
        download(4'b0010, "R3");
        download(4'b0100, "R3");
        download(4'b1000, "R3");

        // R4: reserved address.
        bus_write(3'd7, 16'hFFFF, 1'b0, 1'b0);
        download(4'b1111, "R4");

        // R5: chip select high, strobe low.
        for (int a = 0; a < 7; a++) bus_write(3'(a), 16'h5A5A, 1'b1, 1'b0);
        download(4'b1111, "R5");

        // R6: strobe high, chip select low.
        for (int a = 0; a < 7; a++) bus_write(3'(a), 16'hA5A5, 1'b0, 1'b1);
        download(4'b1111, "R6");

        // R8: enable held low while the halves are rewritten.
        c = cyc;
        ld_ctr_n = 1'b0;
        cs_n = 1'b0; wr_n = 1'b0; addr = 3'd0; wr_data = 16'h1111; m_hold[0] = 16'h1111;
        expect_at(0, {m_hold[1], 16'h1111}, c + 2, "R8");
        @(negedge clk);
        addr = 3'd1; wr_data = 16'h2222; m_hold[1] = 16'h2222;
        expect_at(0, 32'h2222_1111, c + 3, "R8");
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; ld_ctr_n = 1'b1;
        m_ctr = 32'h2222_1111;
        expect_at(0, m_ctr, c + 4, "R8");
        @(negedge clk);
        // R7: after release, a new holding write does not reach the output.
        bus_write(3'd0, 16'h3333, 1'b0, 1'b0);
        expect_at(0, m_ctr, c + 5, "R7");
        @(negedge clk);

        // R10: arm held low for three cycles.
        c = cyc;
        ld_arm_n = 1'b0;
        expect_at(4, 32'd0, c + 1, "R10");
        expect_at(4, 32'd1, c + 2, "R10");
        expect_at(4, 32'd1, c + 3, "R10");
        expect_at(4, 32'd1, c + 4, "R10");
        expect_at(4, 32'd0, c + 5, "R10");
        repeat (3) @(negedge clk);
        ld_arm_n = 1'b1;

        // R9: reload center only; offset, timer and phase must stay put.
        download(4'b0001, "R9");

        repeat (6) @(negedge clk);
        done = 1'b1;
        if (sb.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R7 pending scoreboard items actual=%0d expected=0", sb.size());
        end
        summary();
        $finish;
    end

endmodule